// File: doc/BRIEF.md
# Cartridge Bank Address Mapper

This block is the address translation half of a cartridge memory controller. Four 5-bit configuration words are held elsewhere: a control word, two character bank words and a program bank word. From these and the current bus addresses it works out, with no clock and no state, where each access lands. On the processor side it turns a CPU address in the upper 32 KB window into an 18-bit program ROM address. It also raises a work-RAM enable for the 8 KB window just below that. On the picture side it turns a 14-bit PPU address into a 17-bit character memory address, and it drives the single address line that picks which nametable RAM page answers.

The control word selects everything at once:
- a two-bit field picks one of four nametable arrangements;
- a two-bit field picks one of three program layouts: a 32 KB window, a fixed first bank, or a fixed last bank;
- one bit picks either one 8 KB character bank or two independent 4 KB halves.

A build parameter picks a device variant in which the work RAM can never be switched off.

Top module: `cart_bank_mapper`

## Requirements
- R1: Nametable arrangement field `ctrl_word[1:0]` = 0 drives `nt_page` to constant 0, and = 1 drives it to constant 1, whatever the PPU address.
- R2: `ctrl_word[1:0]` = 2 makes `nt_page` follow `ppu_addr[10]`, and = 3 makes it follow `ppu_addr[11]`.
- R3: Program layout field `ctrl_word[3:2]` of 0 or 1 maps CPU $8000-$FFFF as one 32 KB block. The result is `prg_rom_addr` = {`prg_word[3:1]`, `cpu_addr[14:0]`}, so bit 0 of the bank number has no effect.
- R4: `ctrl_word[3:2]` = 2 maps CPU $8000-$BFFF to bank 0. It maps $C000-$FFFF to bank `prg_word[3:0]`.
- R5: `ctrl_word[3:2]` = 3 maps CPU $8000-$BFFF to bank `prg_word[3:0]`. It maps $C000-$FFFF to bank 15, the last 16 KB bank.
- R6: In every program layout, `prg_rom_addr[13:0]` equals `cpu_addr[13:0]`. Bits 17:14 carry the 16 KB bank number.
- R7: With `ctrl_word[4]` = 0, `chr_addr` = {`chr_word_lo[4:1]`, `ppu_addr[12:0]`}. Bit 0 of `chr_word_lo` and all of `chr_word_hi` have no effect.
- R8: With `ctrl_word[4]` = 1, `chr_addr` = {`chr_word_lo`, `ppu_addr[11:0]`} for PPU $0000-$0FFF and {`chr_word_hi`, `ppu_addr[11:0]`} for PPU $1000-$1FFF.
- R9: `ram_en` is high only for CPU addresses $6000-$7FFF, that is `cpu_addr[15:13]` = 3'b011, and only when the device allows the RAM.
- R10: With `RAM_ALWAYS_ON` = 0, `prg_word[4]` = 1 forces `ram_en` low. With `RAM_ALWAYS_ON` = 1, `prg_word[4]` has no effect on `ram_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | 16 | CPU bus address |
| ppu_addr | input | 14 | PPU bus address |
| ctrl_word | input | 5 | Control word: [1:0] nametable arrangement, [3:2] program layout, [4] character mode |
| chr_word_lo | input | 5 | Character bank for PPU $0000 (or the 8 KB bank) |
| chr_word_hi | input | 5 | Character bank for PPU $1000 in 4 KB mode |
| prg_word | input | 5 | [3:0] program bank, [4] work RAM disable |
| prg_rom_addr | output | 18 | Program ROM address |
| ram_en | output | 1 | Work RAM enable, active high |
| chr_addr | output | 17 | Character memory address |
| nt_page | output | 1 | Nametable RAM page select line |

## Verification
The bench goes after the bank boundaries at $BFFF/$C000 and $0FFF/$1000. A design that splits the window on the wrong address bit sends half of each window to the wrong bank. It loads odd bank numbers in the 32 KB and 8 KB modes. A design that does not drop the low bank bit there would shift every access by one 16 KB or 4 KB page. It probes the $5FFF, $6000, $7FFF and $8000 edges of the RAM window, with the disable bit set and clear, on both device variants. An off-by-one decode there would corrupt I/O or ROM reads, and a variant that honoured the disable bit would lose saved data.

// File: rtl/cart_bank_map_pkg.sv
// Shared constants and field types for the cartridge bank address mapper.
// Assumes a 16-bit CPU bus and a 14-bit PPU bus.
package cart_bank_map_pkg;

    localparam int CPU_AW = 16;
    localparam int PPU_AW = 14;

    // Nametable arrangement codes (control word bits 1:0).
    typedef enum logic [1:0] {
        NT_SINGLE_LO = 2'd0,
        NT_SINGLE_HI = 2'd1,
        NT_SIDE      = 2'd2,
        NT_STACKED   = 2'd3
    } nt_mode_e;

    // Program layout codes (control word bits 3:2).
    typedef enum logic [1:0] {
        PRG_WIDE_A    = 2'd0,
        PRG_WIDE_B    = 2'd1,
        PRG_FIX_FIRST = 2'd2,
        PRG_FIX_LAST  = 2'd3
    } prg_mode_e;

endpackage

// File: rtl/cart_prg_map.sv
// Program ROM translation. Picks the 16 KB bank for the CPU window half
// selected by cpu_lo[14] according to the layout code, then appends the
// in-page offset. Assumes the caller only uses the result for $8000-$FFFF.
module cart_prg_map
    import cart_bank_map_pkg::*;
#(
    parameter int BANK_W  = 4,
    parameter int PAGE_AW = 14,
    localparam int OUT_W  = BANK_W + PAGE_AW
) (
    input  logic [PAGE_AW:0]  cpu_lo,
    input  prg_mode_e         mode,
    input  logic [BANK_W-1:0] bank,
    output logic [OUT_W-1:0]  rom_addr
);

    localparam logic [BANK_W-1:0] FIRST_BANK = '0;
    localparam logic [BANK_W-1:0] LAST_BANK  = '1;

    logic              upper_half;
    logic [BANK_W-1:0] page;

    assign upper_half = cpu_lo[PAGE_AW];

    // Choose the 16 KB page for this half of the window.
    always_comb begin
        unique case (mode)
            PRG_WIDE_A, PRG_WIDE_B: page = {bank[BANK_W-1:1], upper_half};
            PRG_FIX_FIRST:          page = upper_half ? bank : FIRST_BANK;
            PRG_FIX_LAST:           page = upper_half ? LAST_BANK : bank;
            default:                page = bank;
        endcase
    end

    assign rom_addr = {page, cpu_lo[PAGE_AW-1:0]};

endmodule

// File: rtl/cart_chr_map.sv
// Character memory translation. In 8 KB mode the low bank word, minus its
// bit 0, names the page. In 4 KB mode the PPU address bit above the page
// offset picks the low or high bank word.
module cart_chr_map #(
    parameter int BANK_W  = 5,
    parameter int PAGE_AW = 12,
    localparam int OUT_W  = BANK_W + PAGE_AW
) (
    input  logic [PAGE_AW:0]  ppu_lo,
    input  logic              split,
    input  logic [BANK_W-1:0] bank_lo,
    input  logic [BANK_W-1:0] bank_hi,
    output logic [OUT_W-1:0]  chr_addr
);

    logic [BANK_W-1:0] half_bank;

    // Pick the bank word for the current 4 KB half.
    always_comb begin
        half_bank = ppu_lo[PAGE_AW] ? bank_hi : bank_lo;
    end

    // Form the character address for the active mode.
    always_comb begin
        if (split) begin
            chr_addr = {half_bank, ppu_lo[PAGE_AW-1:0]};
        end else begin
            chr_addr = {bank_lo[BANK_W-1:1], ppu_lo};
        end
    end

endmodule

// File: rtl/cart_nt_mirror.sv
// Nametable page select. Drives one of two constants or one of two PPU
// address bits according to the arrangement code.
module cart_nt_mirror
    import cart_bank_map_pkg::*;
(
    input  nt_mode_e   mode,
    input  logic [1:0] ppu_bits,   // {A11, A10}
    output logic       page
);

    // Select the page line source.
    always_comb begin
        unique case (mode)
            NT_SINGLE_LO: page = 1'b0;
            NT_SINGLE_HI: page = 1'b1;
            NT_SIDE:      page = ppu_bits[0];
            NT_STACKED:   page = ppu_bits[1];
            default:      page = 1'b0;
        endcase
    end

endmodule

// File: rtl/cart_ram_gate.sv
// Work RAM enable. Decodes the 8 KB window below the ROM area. The
// ALWAYS_ON variant ignores the disable bit.
module cart_ram_gate #(
    parameter bit ALWAYS_ON = 1'b0
) (
    input  logic [2:0] cpu_top,    // CPU A15..A13
    input  logic       disable_in,
    output logic       ram_en
);

    localparam logic [2:0] RAM_WINDOW = 3'b011;

    logic in_window;
    logic allowed;

    assign in_window = (cpu_top == RAM_WINDOW);

    generate
        if (ALWAYS_ON) begin : g_always_on
            logic unused_disable;
            assign unused_disable = disable_in;
            assign allowed = 1'b1;
        end else begin : g_switchable
            assign allowed = ~disable_in;
        end
    endgenerate

    // Combine window decode and permission.
    always_comb begin
        ram_en = in_window & allowed;
    end

endmodule

// File: rtl/cart_bank_mapper.sv
// Top of the cartridge bank address mapper. Pure combinational: it splits
// the configuration words into fields and hands them to the program,
// character, nametable and work RAM sub-blocks. Assumes the configuration
// words are stable registers held outside this block.
module cart_bank_mapper
    import cart_bank_map_pkg::*;
#(
    parameter int REG_W         = 5,
    parameter int PRG_BANK_W    = 4,
    parameter int PRG_PAGE_AW   = 14,
    parameter int CHR_PAGE_AW   = 12,
    parameter bit RAM_ALWAYS_ON = 1'b0,
    localparam int PRG_AW       = PRG_BANK_W + PRG_PAGE_AW,
    localparam int CHR_AW       = REG_W + CHR_PAGE_AW
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic [REG_W-1:0]  ctrl_word,
    input  logic [REG_W-1:0]  chr_word_lo,
    input  logic [REG_W-1:0]  chr_word_hi,
    input  logic [REG_W-1:0]  prg_word,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic              ram_en,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              nt_page
);

    nt_mode_e  nt_mode;
    prg_mode_e prg_mode;
    logic      chr_split;
    logic      unused_ppu_top;

    // Split the control word into its fields.
    always_comb begin
        nt_mode   = nt_mode_e'(ctrl_word[1:0]);
        prg_mode  = prg_mode_e'(ctrl_word[3:2]);
        chr_split = ctrl_word[4];
    end

    assign unused_ppu_top = ppu_addr[PPU_AW-1];

    cart_prg_map #(
        .BANK_W  (PRG_BANK_W),
        .PAGE_AW (PRG_PAGE_AW)
    ) u_prg (
        .cpu_lo   (cpu_addr[PRG_PAGE_AW:0]),
        .mode     (prg_mode),
        .bank     (prg_word[PRG_BANK_W-1:0]),
        .rom_addr (prg_rom_addr)
    );

    cart_ram_gate #(
        .ALWAYS_ON (RAM_ALWAYS_ON)
    ) u_ram (
        .cpu_top    (cpu_addr[CPU_AW-1:CPU_AW-3]),
        .disable_in (prg_word[REG_W-1]),
        .ram_en     (ram_en)
    );

    cart_chr_map #(
        .BANK_W  (REG_W),
        .PAGE_AW (CHR_PAGE_AW)
    ) u_chr (
        .ppu_lo   (ppu_addr[CHR_PAGE_AW:0]),
        .split    (chr_split),
        .bank_lo  (chr_word_lo),
        .bank_hi  (chr_word_hi),
        .chr_addr (chr_addr)
    );

    cart_nt_mirror u_nt (
        .mode     (nt_mode),
        .ppu_bits (ppu_addr[11:10]),
        .page     (nt_page)
    );

endmodule

// File: rtl/cart_bank_mapper_chk.sv
// Assertion checker for the bank mapper, bound to every instance. The
// block has no clock, so the checks are immediate assertions evaluated
// whenever the ports change.
module cart_bank_mapper_chk
    import cart_bank_map_pkg::*;
#(
    parameter int REG_W         = 5,
    parameter int PRG_BANK_W    = 4,
    parameter int PRG_PAGE_AW   = 14,
    parameter int CHR_PAGE_AW   = 12,
    parameter bit RAM_ALWAYS_ON = 1'b0
) (
    input logic [CPU_AW-1:0]                 cpu_addr,
    input logic [PPU_AW-1:0]                 ppu_addr,
    input logic [REG_W-1:0]                  ctrl_word,
    input logic [REG_W-1:0]                  chr_word_lo,
    input logic [REG_W-1:0]                  chr_word_hi,
    input logic [REG_W-1:0]                  prg_word,
    input logic [PRG_BANK_W+PRG_PAGE_AW-1:0] prg_rom_addr,
    input logic                              ram_en,
    input logic [REG_W+CHR_PAGE_AW-1:0]      chr_addr,
    input logic                              nt_page
);

    logic unused_chk;
    assign unused_chk = ^{chr_word_hi, prg_word[REG_W-2:0]};

    // Check each property against the current port values.
    always_comb begin
        a_r1_single_lo: assert (ctrl_word[1:0] != 2'd0 || nt_page == 1'b0);
        a_r1_single_hi: assert (ctrl_word[1:0] != 2'd1 || nt_page == 1'b1);
        a_r2_side:      assert (ctrl_word[1:0] != 2'd2 || nt_page == ppu_addr[10]);
        a_r2_stacked:   assert (ctrl_word[1:0] != 2'd3 || nt_page == ppu_addr[11]);
        a_r4_first_fix: assert (!(ctrl_word[3:2] == 2'd2 && !cpu_addr[PRG_PAGE_AW])
                                || prg_rom_addr[PRG_BANK_W+PRG_PAGE_AW-1:PRG_PAGE_AW] == '0);
        a_r5_last_fix:  assert (!(ctrl_word[3:2] == 2'd3 && cpu_addr[PRG_PAGE_AW])
                                || prg_rom_addr[PRG_BANK_W+PRG_PAGE_AW-1:PRG_PAGE_AW] == '1);
        a_r6_offset:    assert (prg_rom_addr[PRG_PAGE_AW-1:0] == cpu_addr[PRG_PAGE_AW-1:0]);
        a_r7_wide_chr:  assert (ctrl_word[4]
                                || (chr_addr[CHR_PAGE_AW:0] == ppu_addr[CHR_PAGE_AW:0]
                                    && chr_addr[REG_W+CHR_PAGE_AW-1:CHR_PAGE_AW+1]
                                       == chr_word_lo[REG_W-1:1]));
        a_r8_split_lo:  assert (!(ctrl_word[4] && !ppu_addr[CHR_PAGE_AW])
                                || chr_addr[REG_W+CHR_PAGE_AW-1:CHR_PAGE_AW] == chr_word_lo);
        a_r9_window:    assert (!ram_en || cpu_addr[CPU_AW-1:CPU_AW-3] == 3'b011);
        a_r10_disable:  assert (RAM_ALWAYS_ON || !(ram_en && prg_word[REG_W-1]));
    end

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
    .REG_W         (REG_W),
    .PRG_BANK_W    (PRG_BANK_W),
    .PRG_PAGE_AW   (PRG_PAGE_AW),
    .CHR_PAGE_AW   (CHR_PAGE_AW),
    .RAM_ALWAYS_ON (RAM_ALWAYS_ON)
) u_chk (.*);

// File: tb/sim_cart_bank_mapper.sv
// Bench for the bank mapper: directed corners plus seeded random vectors,
// checked against reference functions written from the requirements.
module sim_cart_bank_mapper;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [15:0] cpu_addr;
    logic [13:0] ppu_addr;
    logic [4:0]  ctrl_word, chr_word_lo, chr_word_hi, prg_word;
    logic [17:0] prg_rom_addr, prg_rom_addr1;
    logic [16:0] chr_addr, chr_addr1;
    logic        ram_en, ram_en1, nt_page, nt_page1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    cart_bank_mapper u0 (
        .cpu_addr, .ppu_addr, .ctrl_word, .chr_word_lo, .chr_word_hi, .prg_word,
        .prg_rom_addr, .ram_en, .chr_addr, .nt_page
    );

    cart_bank_mapper #(.RAM_ALWAYS_ON(1'b1)) u1 (
        .cpu_addr, .ppu_addr, .ctrl_word, .chr_word_lo, .chr_word_hi, .prg_word,
        .prg_rom_addr (prg_rom_addr1), .ram_en (ram_en1),
        .chr_addr (chr_addr1), .nt_page (nt_page1)
    );

    function automatic int exp_prg(int ctrl, int bank, int addr);
        int mode = (ctrl >> 2) & 3;
        int b = bank & 15;
        int pg;
        if (mode < 2) return (b >> 1) * 32768 + (addr & 16'h7FFF);
        if (mode == 2) pg = (addr >= 16'hC000) ? b : 0;
        else           pg = (addr >= 16'hC000) ? 15 : b;
        return pg * 16384 + (addr & 16'h3FFF);
    endfunction

    function automatic int exp_chr(int ctrl, int lo, int hi, int p);
        if (((ctrl >> 4) & 1) == 0) return (lo >> 1) * 8192 + (p & 16'h1FFF);
        return (((p & 16'h1FFF) < 16'h1000) ? lo : hi) * 4096 + (p & 16'h0FFF);
    endfunction

    function automatic int exp_nt(int ctrl, int p);
        case (ctrl & 3)
            0: return 0;
            1: return 1;
            2: return (p >> 10) & 1;
            default: return (p >> 11) & 1;
        endcase
    endfunction

    function automatic int exp_ram(int addr, int prg, int always_on);
        if (addr < 16'h6000 || addr > 16'h7FFF) return 0;
        return (always_on != 0 || ((prg >> 4) & 1) == 0) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cpu=%h ppu=%h ctrl=%h lo=%h hi=%h prg=%h)",
                     req, act, exp, cpu_addr, ppu_addr, ctrl_word, chr_word_lo, chr_word_hi, prg_word);
        end
    endtask

    // Drive one vector at the falling edge and check it mid-phase.
    task automatic apply(int c, int p, int ct, int lo, int hi, int pr);
        string rp, rc, rn;
        @(negedge clk);
        cpu_addr = 16'(c); ppu_addr = 14'(p); ctrl_word = 5'(ct);
        chr_word_lo = 5'(lo); chr_word_hi = 5'(hi); prg_word = 5'(pr);
        #2;
        rp = (((ct >> 2) & 3) < 2) ? "R3" : ((((ct >> 2) & 3) == 2) ? "R4" : "R5");
        rc = (((ct >> 4) & 1) != 0) ? "R8" : "R7";
        rn = ((ct & 3) < 2) ? "R1" : "R2";
        if (c >= 16'h8000) begin
            chk(rp, int'(prg_rom_addr), exp_prg(ct, pr, c));
            chk("R6", int'(prg_rom_addr[13:0]), c & 16'h3FFF);
        end
        chk(rc, int'(chr_addr), exp_chr(ct, lo, hi, p));
        chk(rn, int'(nt_page), exp_nt(ct, p));
        chk((((pr >> 4) & 1) != 0) ? "R10" : "R9", int'(ram_en), exp_ram(c, pr, 0));
        chk("R10", int'(ram_en1), exp_ram(c, pr, 1));
    endtask

    initial begin
        cpu_addr = '0; ppu_addr = '0; ctrl_word = '0;
        chr_word_lo = '0; chr_word_hi = '0; prg_word = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // All-zero configuration right after reset.
        @(negedge clk); #2;
        chk("R3", int'(prg_rom_addr), 0);
        chk("R7", int'(chr_addr), 0);
        chk("R1", int'(nt_page), 0);
        chk("R9", int'(ram_en), 0);
        // Bank window edges in every program layout, odd bank number.
        for (int m = 0; m < 4; m++) begin
            apply(16'h8000, 0, m << 2, 0, 0, 5'h07);
            apply(16'hBFFF, 0, m << 2, 0, 0, 5'h07);
            apply(16'hC000, 0, m << 2, 0, 0, 5'h07);
            apply(16'hFFFF, 0, m << 2, 0, 0, 5'h0B);
        end
        // Character half boundary, both modes, odd low bank.
        for (int s = 0; s < 2; s++) begin
            apply(0, 14'h0FFF, s << 4, 5'h13, 5'h0C, 0);
            apply(0, 14'h1000, s << 4, 5'h13, 5'h0C, 0);
            apply(0, 14'h1FFF, s << 4, 5'h13, 5'h1F, 0);
        end
        // Nametable arrangements with A10/A11 in opposite states.
        for (int n = 0; n < 4; n++) begin
            apply(0, 14'h2400, n, 0, 0, 0);
            apply(0, 14'h2800, n, 0, 0, 0);
        end
        // Work RAM window edges, disable bit clear and set.
        for (int d = 0; d < 2; d++) begin
            apply(16'h5FFF, 0, 0, 0, 0, d << 4);
            apply(16'h6000, 0, 0, 0, 0, d << 4);
            apply(16'h7FFF, 0, 0, 0, 0, d << 4);
            apply(16'h8000, 0, 0, 0, 0, d << 4);
        end
        // Seeded random vectors, half of them in the ROM area.
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            int c = int'($urandom() & 16'hFFFF);
            if (i[0]) c = c | 16'h8000;
            apply(c, int'($urandom() & 14'h3FFF), int'($urandom() & 31),
                  int'($urandom() & 31), int'($urandom() & 31), int'($urandom() & 31));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule